// File: doc/BRIEF.md
# Three-Frame Triggered Raw Capture Controller

This controller runs the raw, non-suppressed readout of a pixel sensor that is read as a rolling shutter. The sensor is scanned without pause, one pixel for each pixel tick. An internal scan counter follows the position in the frame. Each completed frame goes into one of four rotating buffer slots.

When a trigger arrives, three consecutive frames must be kept: the one before the frame being scanned, the frame being scanned, and the one after it. The controller keeps scanning until the frame that follows the trigger frame is complete. It then freezes recording so that no slot is overwritten, and tells the host transfer engine which slot holds the oldest of the three frames. Once the engine signals that the transfer is done, the controller drives a sensor reset pulse of fixed length. After that it starts scanning again from pixel zero.

Busy covers the whole episode, from the trigger to the end of the reset pulse. The time from trigger to freeze therefore lies between one and two frame times, depending on where in the frame the trigger lands.

Top module: `trioCapture`

## Requirements
- R1: After reset the controller is scanning: recEn=1, busy=0, sensorRst=0, pixAddr=0, bufSel=0, xferBase=0.
- R2: While recEn=1, each cycle with pixTick=1 advances pixAddr by one. From FRAME_LEN-1 it wraps to 0, and in that same cycle bufSel advances by one modulo 4. With pixTick=0 neither changes.
- R3: A trigger (trig=1) taken while idle makes busy 1 from the next cycle on. xferBase becomes (bufSel at the trigger cycle - 1) mod 4 and holds that value until the next accepted trigger.
- R4: Recording continues until the last pixel of the frame after the trigger frame has been accepted. recEn falls in the next cycle. Counted from the trigger cycle inclusive, the pixels accepted number at least FRAME_LEN+1 and at most 2*FRAME_LEN.
- R5: While frozen, pixAddr and bufSel do not change, whatever pixTick does. bufSel then equals (xferBase + 3) mod 4.
- R6: xferDone=1 while frozen makes sensorRst 1 from the next cycle for exactly RST_CYCLES cycles. pixAddr reads 0 throughout that pulse.
- R7: In the cycle after the last sensorRst cycle, busy=0, recEn=1 and pixAddr=0. Scanning resumes in the same bufSel slot.
- R8: trig=1 while busy=1 has no effect: xferBase, the freeze point and the reset timing are unchanged.
- R9: xferDone=1 outside the frozen state has no effect: busy and sensorRst stay 0 while idle.
- R10: busy stays 1 without a break from the cycle after an accepted trigger through the last cycle of sensorRst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixTick | input | 1 | One sensor pixel is presented this cycle |
| trig | input | 1 | Trigger request |
| xferDone | input | 1 | Host transfer of the three frames is finished |
| recEn | output | 1 | Pixel data is being recorded into bufSel |
| busy | output | 1 | A trigger is being served |
| sensorRst | output | 1 | Sensor reset pulse |
| pixAddr | output | $clog2(FRAME_LEN) | Pixel position within the frame |
| bufSel | output | 2 | Buffer slot being written |
| xferBase | output | 2 | Slot holding the oldest of the three captured frames |

## Verification
The assertions assume that the transfer engine raises xferDone only after it has seen the freeze. They also assume that pixTick comes from a free-running source that is independent of the controller's state. The bench keeps to both of these. It raises xferDone only once recEn has fallen, apart from one deliberate pulse while idle, and it derives pixTick from a fixed cycle cadence. Triggers are placed on the last pixel of a frame, on pixel zero and mid-frame, to reach both ends of the latency window. Further trigger pulses are applied while the controller is waiting and while it is frozen, to show that they are ignored.

// File: rtl/trioCapturePkg.sv
package trioCapturePkg;

  typedef enum logic [1:0] {
    IDLE_SCAN       = 2'd0,
    WAIT_NEXT_FRAME = 2'd1,
    FROZEN_TRANSFER = 2'd2,
    SENSOR_RESET    = 2'd3
  } capState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic scanRun;    // scan counter may advance
    logic latchTrig;  // capture slot base on accepted trigger
    logic clearScan;  // force pixel position to zero
    logic loadRst;    // arm reset pulse timer
    logic inReset;    // reset pulse in progress
  } capStrobe_t;

endpackage

// File: rtl/trioCaptureDp.sv
module trioCaptureDp
  import trioCapturePkg::*;
#(
  parameter int FRAME_LEN  = 262144,
  parameter int RST_CYCLES = 16,
  localparam int ADDR_W = $clog2(FRAME_LEN),
  localparam int RST_W  = $clog2(RST_CYCLES + 1),
  localparam int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic              pixTick,
  output logic [ADDR_W-1:0] pixAddr,
  output logic [SLOT_W-1:0] bufSel,
  output logic [SLOT_W-1:0] xferBase,
  output logic              frameEnd,
  output logic              slotMatch,
  output logic              rstDone
);

  logic             lastPix;
  logic [RST_W-1:0] rstCnt;

  assign lastPix   = (pixAddr == ADDR_W'(FRAME_LEN - 1));
  assign frameEnd  = strobe.scanRun & pixTick & lastPix;
  // the frame after the trigger frame is written two slots past the base
  assign slotMatch = (bufSel == SLOT_W'(xferBase + SLOT_W'(2)));
  assign rstDone   = (rstCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixAddr <= '0;
      bufSel  <= '0;
    end else if (strobe.clearScan) begin
      pixAddr <= '0;
    end else if (strobe.scanRun && pixTick) begin
      pixAddr <= lastPix ? '0 : ADDR_W'(pixAddr + 1'b1);
      if (lastPix) bufSel <= SLOT_W'(bufSel + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 xferBase <= '0;
    else if (strobe.latchTrig) xferBase <= SLOT_W'(bufSel - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                rstCnt <= '0;
    else if (strobe.loadRst)                  rstCnt <= RST_W'(RST_CYCLES - 1);
    else if (strobe.inReset && rstCnt != '0)  rstCnt <= RST_W'(rstCnt - 1'b1);
  end

endmodule

// File: rtl/trioCaptureCtrl.sv
module trioCaptureCtrl
  import trioCapturePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trig,
  input  logic       xferDone,
  input  logic       frameEnd,
  input  logic       slotMatch,
  input  logic       rstDone,
  output capStrobe_t strobe,
  output logic       recEn,
  output logic       busy,
  output logic       sensorRst
);

  capState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      IDLE_SCAN:       if (trig)                   stateNext = WAIT_NEXT_FRAME;
      WAIT_NEXT_FRAME: if (frameEnd && slotMatch)  stateNext = FROZEN_TRANSFER;
      FROZEN_TRANSFER: if (xferDone)               stateNext = SENSOR_RESET;
      SENSOR_RESET:    if (rstDone)                stateNext = IDLE_SCAN;
      default:                                     stateNext = IDLE_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE_SCAN;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.scanRun   = (state == IDLE_SCAN) || (state == WAIT_NEXT_FRAME);
    strobe.latchTrig = (state == IDLE_SCAN) && trig;
    strobe.clearScan = (state == SENSOR_RESET);
    strobe.loadRst   = (state == FROZEN_TRANSFER) && xferDone;
    strobe.inReset   = (state == SENSOR_RESET);
  end

  assign recEn     = strobe.scanRun;
  assign busy      = (state != IDLE_SCAN);
  assign sensorRst = (state == SENSOR_RESET);

endmodule

// File: rtl/trioCapture.sv
module trioCapture
  import trioCapturePkg::*;
#(
  parameter int FRAME_LEN  = 262144,
  parameter int RST_CYCLES = 16,
  localparam int ADDR_W = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixTick,
  input  logic              trig,
  input  logic              xferDone,
  output logic              recEn,
  output logic              busy,
  output logic              sensorRst,
  output logic [ADDR_W-1:0] pixAddr,
  output logic [1:0]        bufSel,
  output logic [1:0]        xferBase
);

  capStrobe_t strobe;
  logic       frameEnd;
  logic       slotMatch;
  logic       rstDone;

  trioCaptureCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trig      (trig),
    .xferDone  (xferDone),
    .frameEnd  (frameEnd),
    .slotMatch (slotMatch),
    .rstDone   (rstDone),
    .strobe    (strobe),
    .recEn     (recEn),
    .busy      (busy),
    .sensorRst (sensorRst)
  );

  trioCaptureDp #(
    .FRAME_LEN  (FRAME_LEN),
    .RST_CYCLES (RST_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pixTick   (pixTick),
    .pixAddr   (pixAddr),
    .bufSel    (bufSel),
    .xferBase  (xferBase),
    .frameEnd  (frameEnd),
    .slotMatch (slotMatch),
    .rstDone   (rstDone)
  );

endmodule

// File: rtl/trioCaptureChk.sv
module trioCaptureChk #(
  parameter int FRAME_LEN  = 262144,
  parameter int RST_CYCLES = 16,
  localparam int ADDR_W = $clog2(FRAME_LEN)
) (
  input logic              clk,
  input logic              rstN,
  input logic              pixTick,
  input logic              trig,
  input logic              xferDone,
  input logic              recEn,
  input logic              busy,
  input logic              sensorRst,
  input logic [ADDR_W-1:0] pixAddr,
  input logic [1:0]        bufSel,
  input logic [1:0]        xferBase
);

  int rstRun;

  always_ff @(posedge clk) begin
    if (!rstN)          rstRun <= 0;
    else if (sensorRst) rstRun <= rstRun + 1;
    else                rstRun <= 0;
  end

  // R2: wrap of the scan counter rotates the slot
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    recEn && pixTick && pixAddr == ADDR_W'(FRAME_LEN - 1)
    |=> pixAddr == '0 && bufSel == 2'($past(bufSel) + 2'd1));

  // R3: accepted trigger raises busy
  p_busy_on_trig_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy && trig |=> busy);

  // R8: base slot is held while busy
  p_base_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(xferBase));

  // R5: nothing moves while frozen
  p_frozen_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !recEn && !sensorRst && $past(!recEn) |-> $stable(pixAddr) && $stable(bufSel));

  // R6: reset pulse starts only after transfer done
  p_rst_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sensorRst) |-> $past(xferDone) && $past(!recEn));

  // R6: reset pulse length
  p_rst_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sensorRst) |-> rstRun == RST_CYCLES);

  p_rst_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    sensorRst |-> rstRun < RST_CYCLES);

  // R7: busy ends right after reset and scan resumes at zero
  p_resume_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(sensorRst) && recEn && pixAddr == '0);

  // R10: busy cannot drop while recording is frozen
  p_busy_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    !recEn |-> busy);

endmodule

bind trioCapture trioCaptureChk #(
  .FRAME_LEN  (FRAME_LEN),
  .RST_CYCLES (RST_CYCLES)
) u_chk (.*);

// File: tb/trioCapture_tb.sv
module trioCapture_tb;

  localparam int CLK_PERIOD = 10;
  localparam int F   = 16;
  localparam int RST = 5;
  localparam int AW  = $clog2(F);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pixTick = 1'b0;
  logic          trig = 1'b0;
  logic          xferDone = 1'b0;
  logic          recEn, busy, sensorRst;
  logic [AW-1:0] pixAddr;
  logic [1:0]    bufSel, xferBase;

  int checks = 0;
  int fails  = 0;
  int cyc = 0;
  int tickDiv = 1;
  int tickCount = 0;

  // reference model state
  int mPhase = 0;   // 0 scan, 1 waiting, 2 frozen, 3 resetting
  int mAddr = 0, mSlot = 0, mBase = 0, mEnds = 0, mRstLeft = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trioCapture #(.FRAME_LEN(F), .RST_CYCLES(RST)) u_dut (
    .clk(clk), .rstN(rstN), .pixTick(pixTick), .trig(trig), .xferDone(xferDone),
    .recEn(recEn), .busy(busy), .sensorRst(sensorRst),
    .pixAddr(pixAddr), .bufSel(bufSel), .xferBase(xferBase)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mAddr = 0; mSlot = 0; mBase = 0; mEnds = 0; mRstLeft = 0;
    end else begin
      case (mPhase)
        0: begin
          bit ended;
          ended = pixTick && (mAddr == F - 1);
          if (trig) begin
            mBase  = (mSlot + 3) % 4;
            mEnds  = ended ? 1 : 2;
            mPhase = 1;
          end
          if (pixTick) begin
            mAddr = ended ? 0 : mAddr + 1;
            if (ended) mSlot = (mSlot + 1) % 4;
          end
        end
        1: begin
          if (pixTick) begin
            if (mAddr == F - 1) begin
              mAddr = 0;
              mSlot = (mSlot + 1) % 4;
              mEnds--;
              if (mEnds == 0) mPhase = 2;
            end else mAddr++;
          end
        end
        2: if (xferDone) begin mPhase = 3; mRstLeft = RST; end
        default: begin
          mAddr = 0;
          mRstLeft--;
          if (mRstLeft == 0) mPhase = 0;
        end
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compareModel();
    logic [31:0] act, exp;
    string tag;
    act = {recEn, busy, sensorRst, bufSel, xferBase, 24'(pixAddr)};
    exp = {mPhase < 2, mPhase != 0, mPhase == 3, 2'(mSlot), 2'(mBase), 24'(mAddr)};
    case (mPhase)
      0: tag = "R2 model";
      1: tag = "R4 model";
      2: tag = "R5 model";
      default: tag = "R6 model";
    endcase
    check(act == exp, tag, act, exp);
  endtask

  // drive inputs at a falling edge, then compare at the next falling edge
  task automatic step(input bit t, input bit d);
    pixTick  = ((cyc % tickDiv) == 0);
    trig     = t;
    xferDone = d;
    if (recEn && pixTick) tickCount++;
    cyc++;
    @(negedge clk);
    if (rstN) compareModel();
  endtask

  task automatic capture(input int lo, input int hi);
    int s, n;
    bit dropped;
    s = bufSel;
    tickCount = 0;
    dropped = 0;
    step(1, 0);
    check(busy == 1'b1, "R3 busy", busy, 1);
    check(xferBase == 2'((s + 3) % 4), "R3 base", xferBase, (s + 3) % 4);
    step(1, 0);  // ignored while waiting
    check(xferBase == 2'((s + 3) % 4), "R8 base after retrigger", xferBase, (s + 3) % 4);
    n = 0;
    while (recEn && n < 200) begin
      step(0, 0);
      if (!busy) dropped = 1;
      n++;
    end
    check(tickCount >= lo && tickCount <= hi, "R4 latency", tickCount, lo);
    for (int i = 0; i < 8; i++) begin
      step(i[0], 0);
      if (!busy) dropped = 1;
    end
    check(pixAddr == '0 && bufSel == 2'((s + 2) % 4), "R5 frozen", {bufSel, 24'(pixAddr)}, (s + 2) % 4 << 24);
    check(recEn == 1'b0, "R5 recEn", recEn, 0);
    step(0, 1);
    n = 0;
    while (sensorRst && n < 100) begin
      n++;
      if (!busy) dropped = 1;
      check(pixAddr == '0, "R6 addr", pixAddr, 0);
      step(1, 0);  // trigger during reset is ignored
    end
    check(n == RST, "R6 pulse length", n, RST);
    check(!busy && recEn && pixAddr == '0 && bufSel == 2'((s + 2) % 4),
          "R7 resume", {busy, recEn, bufSel}, {2'b01, 2'((s + 2) % 4)});
    check(!dropped, "R10 busy continuous", dropped, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(recEn && !busy && !sensorRst && pixAddr == '0 && bufSel == '0 && xferBase == '0,
          "R1 reset state", {recEn, busy, sensorRst, bufSel, xferBase}, 7'b1000000);
    rstN = 1'b1;
    // plain scanning
    tickDiv = 1;
    for (int i = 0; i < 20; i++) step(0, 0);
    check(bufSel == 2'd1 && pixAddr == AW'(4), "R2 wrap", {bufSel, 24'(pixAddr)}, (1 << 24) | 4);
    tickDiv = 3;
    for (int i = 0; i < 9; i++) step(0, 0);
    // stray transfer done while idle
    step(0, 1);
    check(!busy && !sensorRst, "R9 done ignored", {busy, sensorRst}, 0);
    for (int i = 0; i < 5; i++) step(0, 0);
    check(!busy && recEn, "R9 still scanning", {busy, recEn}, 1);
    // mid-frame trigger with sparse pixels
    tickDiv = 2;
    for (int i = 0; i < 7; i++) step(0, 0);
    capture(F + 1, 2 * F);
    // trigger on the last pixel of a frame: shortest latency
    tickDiv = 1;
    while (pixAddr != AW'(F - 1)) step(0, 0);
    capture(F + 1, F + 1);
    // trigger on pixel zero with a pixel: longest latency
    while (pixAddr != '0) step(0, 0);
    capture(2 * F, 2 * F);
    for (int i = 0; i < 6; i++) step(0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule